// File: doc/BRIEF.md
# Register Alias Rename Table

This block maps the architectural register names used by incoming micro-operations onto a larger pool of physical registers. A speculative alias table holds one entry for each architectural register. Each entry names the physical register that most recently became that register's instance. A free list holds the physical tags that are not in use. Each cycle one micro-operation can arrive. It carries two source register indices and an optional destination index. The block returns the physical tags of both sources from the current table. For a micro-op with a destination, it also hands out a fresh physical tag and reports the tag that the destination previously mapped to. The allocator carries that old tag forward to retirement.

When a micro-op retires, the retirement logic presents its destination, its new tag and its old tag. The block records the new mapping in a committed copy of the table and returns the old tag to the free list. A flush throws away all speculative state. The speculative table is reloaded from the committed copy, and the free list is rebuilt so that it holds every tag that copy does not reference. When a destination needs a tag and none is free, the block raises stall. The allocator then holds the micro-op until a tag is released.

Top module: `rat_rename`

## Requirements
- R1: After reset, every source lookup of architectural register i returns physical tag i. Tags NUM_ARCH to NUM_PHYS-1 (8 to 127 by default) are free, so the first allocation returns tag NUM_ARCH.
- R2: src0_tag and src1_tag give the current speculative mapping of src0_idx and src1_idx in the same cycle. old_tag gives the current mapping of dst_idx. All three are read before the same micro-op's destination update, so a micro-op whose source equals its destination sees the previous instance.
- R3: A micro-op that is accepted with in_valid=1, dst_valid=1, stall=0 and flush=0 is given the lowest-numbered free tag on dst_tag. From the next cycle the table maps dst_idx to that tag, and the tag is no longer free.
- R4: A micro-op with dst_valid=0 consumes no free tag, leaves the table unchanged and never raises stall.
- R5: stall is 1 exactly when in_valid=1, dst_valid=1 and no tag is free. A stalled micro-op changes neither the table nor the free list.
- R6: On commit_valid=1, commit_old_tag becomes free from the next cycle. commit_tag becomes the committed mapping of commit_idx.
- R7: On flush=1, from the next cycle the speculative table equals the committed copy, including a commit presented in the same cycle. The free list then holds exactly the tags that the committed copy does not reference. A micro-op presented during the flush cycle is ignored.
- R8: A tag released by commit becomes allocatable only in the following cycle. A commit in the same cycle does not clear a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A micro-op is presented this cycle |
| src0_idx | input | 3 | Architectural index of the first source |
| src1_idx | input | 3 | Architectural index of the second source |
| dst_valid | input | 1 | The micro-op writes a destination |
| dst_idx | input | 3 | Architectural index of the destination |
| stall | output | 1 | Destination cannot be given a tag; hold the micro-op |
| src0_tag | output | 7 | Physical tag of the first source |
| src1_tag | output | 7 | Physical tag of the second source |
| dst_tag | output | 7 | Freshly allocated physical tag for the destination |
| old_tag | output | 7 | Physical tag the destination mapped to before this micro-op |
| commit_valid | input | 1 | A renamed micro-op with a destination retires |
| commit_idx | input | 3 | Architectural destination of the retiring micro-op |
| commit_tag | input | 7 | Physical tag allocated to the retiring micro-op |
| commit_old_tag | input | 7 | Tag the retiring micro-op replaced; returned to the free list |
| flush | input | 1 | Restore the committed mapping and rebuild the free list |

## Verification
The lookup path is tried on every ordered pair of source indices, with destinations that rotate over all registers. That pattern separates a table that steers readers to the newest instance from one that lags by a cycle or mixes up the entries, and a self-referencing micro-op shows whether the read happens before the update. The pool is driven to exhaustion and then released through commits. This separates lowest-first reuse and correct stall timing, including a release in the same cycle as a stalled micro-op, from a free list that leaks tags or frees them early. Flushes are applied together with a same-cycle micro-op and a commit. The table and the allocation order that follow show whether the committed copy and the rebuilt free list agree.

// File: rtl/rat_pkg.sv
package rat_pkg;
   localparam int unsigned DEF_ARCH = 8;
   localparam int unsigned DEF_PHYS = 128;

   typedef enum logic [1:0] {
      UPD_HOLD   = 2'd0,
      UPD_RENAME = 2'd1,
      UPD_FLUSH  = 2'd2
   } upd_e;
endpackage

// File: rtl/rat_map.sv
module rat_map #(
   parameter int unsigned NA = rat_pkg::DEF_ARCH,
   parameter int unsigned NP = rat_pkg::DEF_PHYS,
   localparam int unsigned TW = $clog2(NP),
   localparam int unsigned AW = $clog2(NA)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          rd0_idx,
   input  logic [AW-1:0]          rd1_idx,
   input  logic [AW-1:0]          rd_dst_idx,
   output logic [TW-1:0]          rd0_tag,
   output logic [TW-1:0]          rd1_tag,
   output logic [TW-1:0]          rd_old_tag,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_idx,
   input  logic [TW-1:0]          wr_tag,
   input  logic                   cm_en,
   input  logic [AW-1:0]          cm_idx,
   input  logic [TW-1:0]          cm_tag,
   input  logic                   flush,
   output logic [NA-1:0][TW-1:0]  comm_next
);
   logic [NA-1:0][TW-1:0] spec_q;
   logic [NA-1:0][TW-1:0] comm_q;
   rat_pkg::upd_e         sel;

   assign rd0_tag    = spec_q[rd0_idx];
   assign rd1_tag    = spec_q[rd1_idx];
   assign rd_old_tag = spec_q[rd_dst_idx];

   always_comb begin
      comm_next = comm_q;
      if (cm_en) comm_next[cm_idx] = cm_tag;
   end

   always_comb begin
      if (flush)      sel = rat_pkg::UPD_FLUSH;
      else if (wr_en) sel = rat_pkg::UPD_RENAME;
      else            sel = rat_pkg::UPD_HOLD;
   end

   for (genvar i = 0; i < NA; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            spec_q[i] <= TW'(i);
            comm_q[i] <= TW'(i);
         end else begin
            comm_q[i] <= comm_next[i];
            case (sel)
               rat_pkg::UPD_FLUSH:  spec_q[i] <= comm_next[i];
               rat_pkg::UPD_RENAME: if (wr_idx == AW'(i)) spec_q[i] <= wr_tag;
               default:             spec_q[i] <= spec_q[i];
            endcase
         end
      end
   end
endmodule

// File: rtl/rat_freelist.sv
module rat_freelist #(
   parameter int unsigned NA = rat_pkg::DEF_ARCH,
   parameter int unsigned NP = rat_pkg::DEF_PHYS,
   localparam int unsigned TW = $clog2(NP)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_en,
   output logic [TW-1:0]         alloc_tag,
   output logic                  empty,
   input  logic                  rel_en,
   input  logic [TW-1:0]         rel_tag,
   input  logic                  flush,
   input  logic [NA-1:0][TW-1:0] comm_next,
   output logic [NP-1:0]         free_vec
);
   logic [NP-1:0] free_q;
   logic [NP-1:0] live;
   logic [NP-1:0] take;
   logic [NP-1:0] give;

   assign free_vec = free_q;
   assign empty    = ~|free_q;

   always_comb begin
      alloc_tag = '0;
      for (int t = NP - 1; t >= 0; t--) begin
         if (free_q[t]) alloc_tag = TW'(t);
      end
   end

   always_comb begin
      live = '0;
      for (int a = 0; a < NA; a++) live[comm_next[a]] = 1'b1;
   end

   always_comb begin
      take = '0;
      give = '0;
      if (alloc_en) take[alloc_tag] = 1'b1;
      if (rel_en)   give[rel_tag]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < NP; t++) free_q[t] <= (t >= NA);
      end else if (flush) begin
         free_q <= ~live;
      end else begin
         free_q <= (free_q & ~take) | give;
      end
   end
endmodule

// File: rtl/rat_rename.sv
module rat_rename #(
   parameter int unsigned NUM_ARCH = rat_pkg::DEF_ARCH,
   parameter int unsigned NUM_PHYS = rat_pkg::DEF_PHYS,
   localparam int unsigned TW = $clog2(NUM_PHYS),
   localparam int unsigned AW = $clog2(NUM_ARCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [AW-1:0] src0_idx,
   input  logic [AW-1:0] src1_idx,
   input  logic          dst_valid,
   input  logic [AW-1:0] dst_idx,
   output logic          stall,
   output logic [TW-1:0] src0_tag,
   output logic [TW-1:0] src1_tag,
   output logic [TW-1:0] dst_tag,
   output logic [TW-1:0] old_tag,
   input  logic          commit_valid,
   input  logic [AW-1:0] commit_idx,
   input  logic [TW-1:0] commit_tag,
   input  logic [TW-1:0] commit_old_tag,
   input  logic          flush
);
   if (NUM_PHYS <= NUM_ARCH) begin : g_bad_pool
      $error("rat_rename: physical pool must exceed architectural count");
   end
   if (NUM_ARCH < 2) begin : g_bad_arch
      $error("rat_rename: need at least two architectural registers");
   end

   logic                        empty;
   logic                        accept_dst;
   logic [TW-1:0]               alloc_tag;
   logic [NUM_ARCH-1:0][TW-1:0] comm_next;
   logic [NUM_PHYS-1:0]         free_vec;

   assign stall      = in_valid & dst_valid & empty;
   assign accept_dst = in_valid & dst_valid & ~empty & ~flush;
   assign dst_tag    = alloc_tag;

   rat_map #(.NA(NUM_ARCH), .NP(NUM_PHYS)) map_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd0_idx    (src0_idx),
      .rd1_idx    (src1_idx),
      .rd_dst_idx (dst_idx),
      .rd0_tag    (src0_tag),
      .rd1_tag    (src1_tag),
      .rd_old_tag (old_tag),
      .wr_en      (accept_dst),
      .wr_idx     (dst_idx),
      .wr_tag     (alloc_tag),
      .cm_en      (commit_valid),
      .cm_idx     (commit_idx),
      .cm_tag     (commit_tag),
      .flush      (flush),
      .comm_next  (comm_next)
   );

   rat_freelist #(.NA(NUM_ARCH), .NP(NUM_PHYS)) fl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (accept_dst),
      .alloc_tag (alloc_tag),
      .empty     (empty),
      .rel_en    (commit_valid),
      .rel_tag   (commit_old_tag),
      .flush     (flush),
      .comm_next (comm_next),
      .free_vec  (free_vec)
   );
endmodule

// File: rtl/rat_rename_chk.sv
module rat_rename_chk #(
   parameter int unsigned NUM_ARCH = rat_pkg::DEF_ARCH,
   parameter int unsigned NUM_PHYS = rat_pkg::DEF_PHYS,
   localparam int unsigned TW = $clog2(NUM_PHYS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                dst_valid,
   input logic                flush,
   input logic                stall,
   input logic [TW-1:0]       dst_tag,
   input logic [TW-1:0]       old_tag,
   input logic                commit_valid,
   input logic [TW-1:0]       commit_old_tag,
   input logic [NUM_PHYS-1:0] free_vec
);
   p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_valid && !stall && !flush) |-> (free_vec[dst_tag] && dst_tag != old_tag));

   p_alloc_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_valid && !stall && !flush && !(commit_valid && commit_old_tag == dst_tag))
      |=> !free_vec[$past(dst_tag)]);

   p_stall_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (free_vec == '0));

   p_nodst_nostall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dst_valid) |-> !stall);

   p_idle_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !commit_valid && !(in_valid && dst_valid)) |=> $stable(free_vec));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && !flush) |=> free_vec[$past(commit_old_tag)]);

   p_flush_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ($countones(free_vec) == NUM_PHYS - NUM_ARCH));
endmodule

bind rat_rename rat_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .dst_valid      (dst_valid),
   .flush          (flush),
   .stall          (stall),
   .dst_tag        (dst_tag),
   .old_tag        (old_tag),
   .commit_valid   (commit_valid),
   .commit_old_tag (commit_old_tag),
   .free_vec       (free_vec)
);

// File: tb/rat_rename_tb.sv
module rat_rename_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NA = 8;
   localparam int NP = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] src0_idx = '0;
   logic [2:0] src1_idx = '0;
   logic       dst_valid = 1'b0;
   logic [2:0] dst_idx = '0;
   logic       stall;
   logic [6:0] src0_tag, src1_tag, dst_tag, old_tag;
   logic       commit_valid = 1'b0;
   logic [2:0] commit_idx = '0;
   logic [6:0] commit_tag = '0;
   logic [6:0] commit_old_tag = '0;
   logic       flush = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rat_rename dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src0_idx(src0_idx),
      .src1_idx(src1_idx), .dst_valid(dst_valid), .dst_idx(dst_idx),
      .stall(stall), .src0_tag(src0_tag), .src1_tag(src1_tag),
      .dst_tag(dst_tag), .old_tag(old_tag), .commit_valid(commit_valid),
      .commit_idx(commit_idx), .commit_tag(commit_tag),
      .commit_old_tag(commit_old_tag), .flush(flush)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   int spec_m [NA];
   int comm_m [NA];
   bit free_m [NP];
   int pq_a [1024];
   int pq_n [1024];
   int pq_o [1024];
   int pq_wr = 0;
   int pq_rd = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int t = 0; t < NP; t++) if (free_m[t]) return t;
      return -1;
   endfunction

   task automatic set_idle();
      in_valid = 0; dst_valid = 0; commit_valid = 0; flush = 0;
   endtask

   task automatic rename(input string req, input int s0, input int s1, input bit dv, input int d);
      int low;
      @(negedge clk);
      set_idle();
      in_valid = 1; src0_idx = 3'(s0); src1_idx = 3'(s1); dst_valid = dv; dst_idx = 3'(d);
      #1;
      low = lowest_free();
      check(req, "src0_tag", int'(src0_tag), spec_m[s0]);
      check(req, "src1_tag", int'(src1_tag), spec_m[s1]);
      check(dv ? req : "R4", "stall", int'(stall), (dv && low < 0) ? 1 : 0);
      if (dv && low >= 0) begin
         check(req, "dst_tag", int'(dst_tag), low);
         check(req, "old_tag", int'(old_tag), spec_m[d]);
      end
      @(posedge clk);
      if (dv && low >= 0) begin
         free_m[low] = 0;
         pq_a[pq_wr % 1024] = d; pq_n[pq_wr % 1024] = low; pq_o[pq_wr % 1024] = spec_m[d];
         pq_wr++;
         spec_m[d] = low;
      end
   endtask

   task automatic commit_one(input bit with_stalled_op);
      int i;
      if (pq_rd == pq_wr) return;
      i = pq_rd % 1024;
      @(negedge clk);
      set_idle();
      commit_valid = 1; commit_idx = 3'(pq_a[i]); commit_tag = 7'(pq_n[i]); commit_old_tag = 7'(pq_o[i]);
      if (with_stalled_op) begin
         in_valid = 1; dst_valid = 1; dst_idx = 3'd6;
         #1;
         check("R8", "stall with same-cycle release", int'(stall), 1);
      end
      @(posedge clk);
      comm_m[pq_a[i]] = pq_n[i];
      free_m[pq_o[i]] = 1;
      pq_rd++;
   endtask

   task automatic do_flush(input bit with_commit);
      int i;
      @(negedge clk);
      set_idle();
      flush = 1; in_valid = 1; dst_valid = 1; dst_idx = 3'd5; src0_idx = 0; src1_idx = 0;
      if (with_commit && pq_rd != pq_wr) begin
         i = pq_rd % 1024;
         commit_valid = 1; commit_idx = 3'(pq_a[i]); commit_tag = 7'(pq_n[i]); commit_old_tag = 7'(pq_o[i]);
         comm_m[pq_a[i]] = pq_n[i];
      end
      @(posedge clk);
      for (int t = 0; t < NP; t++) free_m[t] = 1;
      for (int a = 0; a < NA; a++) begin
         spec_m[a] = comm_m[a];
         free_m[comm_m[a]] = 0;
      end
      pq_rd = 0; pq_wr = 0;
   endtask

   task automatic check_table(input string req);
      for (int a = 0; a < NA; a++) begin
         @(negedge clk);
         set_idle();
         src0_idx = 3'(a); src1_idx = 3'((a + 1) % NA);
         #1;
         check(req, "table src0", int'(src0_tag), spec_m[a]);
         check(req, "table src1", int'(src1_tag), spec_m[(a + 1) % NA]);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         report();
      end
   end

   initial begin
      int k;
      for (int a = 0; a < NA; a++) begin spec_m[a] = a; comm_m[a] = a; end
      for (int t = 0; t < NP; t++) free_m[t] = (t >= NA);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1: identity mapping and idle stall
      check_table("R1");
      check("R1", "stall idle", int'(stall), 0);
      rename("R1", 0, 7, 1, 3);

      // R2: self-referencing micro-op reads the old instance
      rename("R2", 1, 1, 1, 1);
      rename("R2", 1, 3, 1, 1);

      // R2/R3: every source pair, rotating destinations
      for (int s0 = 0; s0 < NA; s0++)
         for (int s1 = 0; s1 < NA; s1++)
            rename("R3", s0, s1, 1, (s0 + 3 * s1) % NA);

      // R4: no destination consumes nothing
      for (int j = 0; j < 3; j++) rename("R4", j, 7 - j, 0, j);
      check_table("R4");
      rename("R4", 2, 2, 1, 2);

      // R6: commits release tags, reused lowest first
      for (int j = 0; j < 20; j++) commit_one(0);
      for (int j = 0; j < 10; j++) rename("R6", j % NA, (j + 5) % NA, 1, (j + 2) % NA);

      // R5: exhaust the pool
      k = 0;
      while (lowest_free() >= 0) begin
         rename("R3", k % NA, (k + 1) % NA, 1, (k * 5) % NA);
         k++;
      end
      rename("R5", 3, 4, 1, 2);
      rename("R5", 5, 6, 1, 7);
      check_table("R5");
      rename("R4", 2, 3, 0, 0);

      // R8: release in the same cycle as a stalled micro-op
      commit_one(1);
      rename("R8", 6, 0, 1, 6);
      rename("R5", 0, 1, 1, 0);

      // R7: flush with same-cycle micro-op and commit
      commit_one(0);
      commit_one(0);
      do_flush(1);
      check_table("R7");
      for (int j = 0; j < 12; j++) rename("R7", j % NA, (j * 3) % NA, 1, (j * 7) % NA);
      for (int j = 0; j < 6; j++) commit_one(0);
      do_flush(0);
      check_table("R7");
      rename("R7", 4, 5, 1, 4);

      done = 1;
      report();
   end
endmodule